// File: doc/BRIEF.md
# Lane Reset Release Sequencer

This block brings a four-lane serial transceiver out of reset in a fixed, timed order. A start pulse drives every power-down, lane-reset and PLL-reset control to its asserted level at once. After one step interval the controls are released one group at a time, lanes 0/1 first and then lanes 2/3. Each pair goes through power, then PLL, then lane reset. One full step interval separates each release from the next, and one more interval follows the last release. A single-cycle done pulse then marks completion. A static per-lane configuration field passes straight through to the transceiver alongside the controls.

A separate helper drives an active-low PCS reset. On its trigger it pulls the reset low for a fixed number of cycles and then releases it. Both intervals are parameters in clock cycles. The defaults, 1500 and 2000 cycles, give 15 us and 20 us at 100 MHz.

Sequencer states: `SQ_IDLE` (after reset, all controls asserted), `SQ_HOLD` (all asserted, first interval running), `SQ_W1` to `SQ_W6` (the Nth group released, its interval running) and `SQ_READY` (all released). Transitions:
- `SQ_IDLE` or `SQ_READY` go to `SQ_HOLD` on start.
- `SQ_HOLD` goes to `SQ_W1` on interval expiry.
- `SQ_Wn` goes to `SQ_Wn+1` on expiry.
- `SQ_W6` goes to `SQ_READY` on expiry, raising done.

Helper states: `PC_LOW` (reset driven low, entered on trigger or block reset) and `PC_IDLE` (reset released). `PC_LOW` goes to `PC_IDLE` on expiry, and `PC_IDLE` goes to `PC_LOW` on trigger.

Top module: `lane_rst_seq`

## Requirements
- R1: `cfg_out` equals `cfg_in` in every cycle, whatever the state.
- R2: On a start seen in idle or ready, the next cycle shows busy high and all controls asserted: `pwrdn`=4'hF, `pll_rst`=2'b11, `lane_rst`=4'hF, with 1 meaning asserted.
- R3: Releases happen one group per step, in this order: `pwrdn[1:0]`, then `pll_rst[0]`, then `lane_rst[1:0]`, then `pwrdn[3:2]`, then `pll_rst[1]`, then `lane_rst[3:2]`.
- R4: If the start is sampled at edge e, group n (1..6) is released at edge e+n*STEP_CYC. The controls are unchanged in the cycles between releases.
- R5: The PCS reset goes low for exactly PCS_CYC cycles after its trigger edge, or after the last reset edge. A trigger while it is low has no effect.
- R6: A start while busy is ignored, including one on a cycle where a step interval expires.
- R7: `done` is high for exactly one cycle, following edge e+7*STEP_CYC. `busy` drops at that same edge.
- R8: Synchronous reset gives `SQ_IDLE` with every control asserted, busy and done low, and `pcs_rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a release sequence |
| pcs_start | input | 1 | Triggers the PCS reset pulse |
| cfg_in | input | 4*CFG_W | Static per-lane configuration |
| cfg_out | output | 4*CFG_W | Configuration to the transceiver |
| pwrdn | output | 4 | Per-lane power-down, 1 = down |
| pll_rst | output | 2 | PLL reset per lane pair, 1 = reset |
| lane_rst | output | 4 | Per-lane reset, 1 = reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pcs_rst_n | output | 1 | PCS reset, active low |

## Verification
The collisions of interest fall in the last cycle of a step interval. There, a second start arrives on the same cycle as the step expiry, and a PCS trigger arrives in that cycle too. The bench drives all three together during the second-to-third release boundary. It judges the outcome against the schedule computed from the original start edge: the release must land on time and the run must not restart. The PCS pulse launched there must run its full, independently timed length. A retrigger of the PCS helper part-way through its low time is checked the same way.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    typedef enum logic [3:0] {
        SQ_IDLE, SQ_HOLD, SQ_W1, SQ_W2, SQ_W3, SQ_W4, SQ_W5, SQ_W6, SQ_READY
    } sq_state_e;

    typedef enum logic {
        PC_IDLE, PC_LOW
    } pc_state_e;

    localparam int unsigned NUM_LANES  = 4;
    localparam int unsigned NUM_PAIRS  = 2;
    localparam int unsigned PAIR_STEPS = 3;
endpackage

// File: rtl/lrs_timer.sv
module lrs_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expired
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/lrs_pcs_pulse.sv
module lrs_pcs_pulse
    import lrs_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic rst_n_o
);
    pc_state_e st, st_nx;
    logic      exp_w;

    lrs_timer #(.LIMIT(PULSE_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   ((st == PC_IDLE) || exp_w),
        .expired (exp_w)
    );

    always_ff @(posedge clk) begin
        if (rst) st <= PC_LOW;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PC_IDLE: if (trig)  st_nx = PC_LOW;
            PC_LOW:  if (exp_w) st_nx = PC_IDLE;
            default: st_nx = PC_LOW;
        endcase
    end

    assign rst_n_o = (st == PC_IDLE);

    assert_pcs_release_on_expiry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> $past(exp_w));
    assert_pcs_retrigger_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst_n_o && !exp_w && trig) |=> !rst_n_o);
endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq
    import lrs_pkg::*;
#(
    parameter int unsigned STEP_CYC = 1500,
    parameter int unsigned PCS_CYC  = 2000,
    parameter int unsigned CFG_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic                           pcs_start,
    input  logic [NUM_LANES*CFG_W-1:0]     cfg_in,
    output logic [NUM_LANES*CFG_W-1:0]     cfg_out,
    output logic [NUM_LANES-1:0]           pwrdn,
    output logic [NUM_PAIRS-1:0]           pll_rst,
    output logic [NUM_LANES-1:0]           lane_rst,
    output logic                           busy,
    output logic                           done,
    output logic                           pcs_rst_n
);
    sq_state_e state, state_nx;
    logic      busy_st;
    logic      step_exp;
    logic      done_q;
    logic [2:0] rel_lvl;

    assign busy_st = (state != SQ_IDLE) && (state != SQ_READY);

    lrs_timer #(.LIMIT(STEP_CYC)) u_step_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (!busy_st || step_exp),
        .expired (step_exp)
    );

    lrs_pcs_pulse #(.PULSE_CYC(PCS_CYC)) u_pcs (
        .clk     (clk),
        .rst     (rst),
        .trig    (pcs_start),
        .rst_n_o (pcs_rst_n)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE, SQ_READY: if (start)    state_nx = SQ_HOLD;
            SQ_HOLD:           if (step_exp) state_nx = SQ_W1;
            SQ_W1:             if (step_exp) state_nx = SQ_W2;
            SQ_W2:             if (step_exp) state_nx = SQ_W3;
            SQ_W3:             if (step_exp) state_nx = SQ_W4;
            SQ_W4:             if (step_exp) state_nx = SQ_W5;
            SQ_W5:             if (step_exp) state_nx = SQ_W6;
            SQ_W6:             if (step_exp) state_nx = SQ_READY;
            default:           state_nx = SQ_IDLE;
        endcase
    end

    // Outputs: number of groups released so far
    always_comb begin
        rel_lvl = 3'd0;
        unique case (state)
            SQ_IDLE, SQ_HOLD: rel_lvl = 3'd0;
            SQ_W1:            rel_lvl = 3'd1;
            SQ_W2:            rel_lvl = 3'd2;
            SQ_W3:            rel_lvl = 3'd3;
            SQ_W4:            rel_lvl = 3'd4;
            SQ_W5:            rel_lvl = 3'd5;
            SQ_W6, SQ_READY:  rel_lvl = 3'd6;
            default:          rel_lvl = 3'd0;
        endcase
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int unsigned BASE = p * PAIR_STEPS;
        assign pwrdn[2*p +: 2]    = (32'(rel_lvl) >= BASE + 1) ? 2'b00 : 2'b11;
        assign pll_rst[p]         = (32'(rel_lvl) <  BASE + 2);
        assign lane_rst[2*p +: 2] = (32'(rel_lvl) >= BASE + 3) ? 2'b00 : 2'b11;
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= (state == SQ_W6) && step_exp;
    end

    assign busy    = busy_st;
    assign done    = done_q;
    assign cfg_out = cfg_in;

    assert_step_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_st && !step_exp) |=> $stable(state));
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (state inside {SQ_W1, SQ_W2, SQ_W3, SQ_W4, SQ_W5, SQ_W6} && start) |=> state != SQ_HOLD);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_last_release_order_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(lane_rst[3]) |-> (pwrdn == 4'h0 && pll_rst == 2'b00 && lane_rst[1:0] == 2'b00));
    assert_pll_after_power_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_rst[0]) |-> (pwrdn[1:0] == 2'b00 && lane_rst[1:0] == 2'b11));
endmodule

// File: tb/lane_rst_seq_test.sv
module lane_rst_seq_test;
    localparam int STEP = 5;
    localparam int PCS  = 7;
    localparam int CW   = 4;

    logic clk = 1'b0;
    logic rst, start, pcs_start;
    logic [4*CW-1:0] cfg_in, cfg_out;
    logic [3:0] pwrdn, lane_rst;
    logic [1:0] pll_rst;
    logic busy, done, pcs_rst_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lane_rst_seq #(.STEP_CYC(STEP), .PCS_CYC(PCS), .CFG_W(CW)) uut (
        .clk(clk), .rst(rst), .start(start), .pcs_start(pcs_start),
        .cfg_in(cfg_in), .cfg_out(cfg_out), .pwrdn(pwrdn), .pll_rst(pll_rst),
        .lane_rst(lane_rst), .busy(busy), .done(done), .pcs_rst_n(pcs_rst_n)
    );

    // Expected {pwrdn, pll_rst, lane_rst} after s releases
    function automatic logic [9:0] exp_ctl(int s);
        logic [3:0] pd, lr;
        logic [1:0] pl;
        pd[1:0] = (s >= 1) ? 2'b00 : 2'b11;
        pl[0]   = (s < 2);
        lr[1:0] = (s >= 3) ? 2'b00 : 2'b11;
        pd[3:2] = (s >= 4) ? 2'b00 : 2'b11;
        pl[1]   = (s < 5);
        lr[3:2] = (s >= 6) ? 2'b00 : 2'b11;
        return {pd, pl, lr};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_seq(bit inject);
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        chk("R2 busy", 32'(busy), 1);
        chk("R2 all asserted", 32'({pwrdn, pll_rst, lane_rst}), 32'(exp_ctl(0)));
        for (int s = 0; s < 7; s++) begin
            wait_cyc(STEP - 1);
            chk("R4 steady before step", 32'({pwrdn, pll_rst, lane_rst}), 32'(exp_ctl(s)));
            chk("R7 done low early", 32'(done), 0);
            if (inject && s == 2) begin
                start = 1'b1;
                pcs_start = 1'b1;
            end
            wait_cyc(1);
            if (inject && s == 2) begin
                start = 1'b0;
                pcs_start = 1'b0;
                chk("R5 pcs low on trigger", 32'(pcs_rst_n), 0);
            end
            if (s < 6) begin
                chk("R3 release order", 32'({pwrdn, pll_rst, lane_rst}), 32'(exp_ctl(s + 1)));
                chk("R6 busy kept", 32'(busy), 1);
            end else begin
                chk("R7 done pulse", 32'(done), 1);
                chk("R7 busy drops", 32'(busy), 0);
                chk("R3 all released", 32'({pwrdn, pll_rst, lane_rst}), 32'(exp_ctl(6)));
            end
        end
        wait_cyc(1);
        chk("R7 done one cycle", 32'(done), 0);
        chk("R5 pcs high at end", 32'(pcs_rst_n), 1);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; pcs_start = 1'b0; cfg_in = 16'hA5C3;
        wait_cyc(3);
        chk("R8 controls", 32'({pwrdn, pll_rst, lane_rst}), 32'(exp_ctl(0)));
        chk("R8 busy", 32'(busy), 0);
        chk("R8 done", 32'(done), 0);
        chk("R8 pcs", 32'(pcs_rst_n), 0);
        chk("R1 passthrough", 32'(cfg_out), 32'(cfg_in));
        rst = 1'b0;
        wait_cyc(PCS - 1);
        chk("R5 low after reset", 32'(pcs_rst_n), 0);
        wait_cyc(1);
        chk("R5 high after reset", 32'(pcs_rst_n), 1);

        // PCS pulse with retrigger while low
        pcs_start = 1'b1;
        wait_cyc(1);
        pcs_start = 1'b0;
        chk("R5 pulse starts", 32'(pcs_rst_n), 0);
        wait_cyc(2);
        pcs_start = 1'b1;
        wait_cyc(1);
        pcs_start = 1'b0;
        wait_cyc(PCS - 4);
        chk("R5 still low", 32'(pcs_rst_n), 0);
        wait_cyc(1);
        chk("R5 retrigger ignored", 32'(pcs_rst_n), 1);

        // Sweep of sequences over config patterns
        for (int r = 0; r < 3; r++) begin
            cfg_in = 16'h1234 * 16'(r + 1) ^ 16'h0F0F;
            chk("R1 passthrough run", 32'(cfg_out), 32'(cfg_in));
            run_seq(r == 1);
        end

        // Reset mid-sequence
        start = 1'b1;
        wait_cyc(1);
        start = 1'b0;
        wait_cyc(4 * STEP);
        chk("R4 mid run level", 32'({pwrdn, pll_rst, lane_rst}), 32'(exp_ctl(4)));
        rst = 1'b1;
        wait_cyc(1);
        chk("R8 controls mid reset", 32'({pwrdn, pll_rst, lane_rst}), 32'(exp_ctl(0)));
        chk("R8 busy mid reset", 32'(busy), 0);
        chk("R8 pcs mid reset", 32'(pcs_rst_n), 0);
        rst = 1'b0;
        wait_cyc(1);
        run_seq(1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule